// File: doc/BRIEF.md
# Message Buffer Interrupt Aggregator

This block gathers completion events from up to 64 message buffers of a CAN-style controller into sticky flags. It applies a per-buffer enable mask and drives grouped interrupt lines and one combined interrupt line to the CPU. Five controller status events (bus off, error, transmit warning, receive warning, wake-up) are handled the same way. Each of them has its own flag, enable bit and interrupt line. The events arrive from neighbouring logic as single-cycle pulses.

A small register port lets software read every flag and mask. Flags are cleared by writing ones, and a set event in the same cycle always wins over a clear. A count register limits how many buffers are live. A FIFO-mode input turns the lowest eight buffer flags into three receive-FIFO status flags.

Top module: `mb_irq_aggregator`

## Requirements
- R1: A `mb_done_i[i]` pulse for a live buffer sets flag i. Flag i reads at address 0 bit i (i<32) or address 1 bit i-32 from the cycle after the pulse. Transmit and receive completions are not told apart.
- R2: Writing 1 to a flag bit (addresses 0, 1, 4) clears it. Writing 0 to a flag bit has no effect.
- R3: A set event in the same cycle as a write-one clear of that bit leaves the flag set.
- R4: Buffer enable masks are read/write at address 2 (buffers 0-31) and address 3 (buffers 32-63). A set flag produces no interrupt while its mask bit is 0.
- R5: `irq_grp_o[g]` for g=0..3 is the OR of enabled flags 4g..4g+3. `irq_grp_o[4]` covers buffers 16-31, and `irq_grp_o[5]` covers buffers 32-63. The lines are level outputs that rise one cycle after the flag becomes readable and fall one cycle after it is cleared.
- R6: `irq_any_o` is the OR of all enabled buffer interrupt sources, with the same timing as the group lines.
- R7: While `fifo_mode_i` is 1, address 0 bit 7 is set by `fifo_ovf_i`, bit 6 by `fifo_warn_i` and bit 5 by `fifo_avail_i`. Bits 4..0 read zero and never interrupt, and `mb_done_i[7:0]` is ignored.
- R8: Status flags sit at address 4 (bit 0 bus off, 1 error, 2 transmit warning, 3 receive warning, 4 wake-up), with W1C and set-wins behaviour. Their masks are at address 5. `irq_sts_o[k]` is flag k AND mask k, registered.
- R9: Address 6 bits 6:0 hold the live buffer count, with values above 64 acting as 64. Flags of buffers at or above the count never set and read zero.
- R10: After reset, all flags and masks are zero, all interrupt outputs are low and the count reads 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mb_done_i | input | 64 | Per-buffer completion pulses |
| fifo_mode_i | input | 1 | Receive FIFO mode enable |
| fifo_ovf_i | input | 1 | FIFO overflow pulse |
| fifo_warn_i | input | 1 | FIFO warning pulse |
| fifo_avail_i | input | 1 | FIFO frames-available pulse |
| sts_evt_i | input | 5 | Status event pulses (bus off, error, tx warn, rx warn, wake-up) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_grp_o | output | 6 | Grouped buffer interrupt lines |
| irq_any_o | output | 1 | Combined buffer interrupt line |
| irq_sts_o | output | 5 | Status interrupt lines |

## Verification
The hardest case to reach from the ports is a completion pulse landing in the very cycle that software writes a one to the same bit. The bench drives both at one clock edge and then reads the flag back. The buffer-count boundary is the other hard case. For each of several counts, the bench pulses all 64 buffers together and compares both flag words against a mask computed from the count. It also sweeps every buffer singly, checking that exactly the expected group line rises and falls.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  localparam int FLAG_W   = 32;
  localparam int NUM_MB   = 2 * FLAG_W;
  localparam int NUM_STS  = 5;
  localparam int CNT_W    = $clog2(NUM_MB) + 1;

  typedef enum logic [2:0] {
    RA_FLAG_LO = 3'd0,
    RA_FLAG_HI = 3'd1,
    RA_MASK_LO = 3'd2,
    RA_MASK_HI = 3'd3,
    RA_STS_FLG = 3'd4,
    RA_STS_MSK = 3'd5,
    RA_COUNT   = 3'd6
  } reg_addr_e;

  localparam int FIFO_SPAN   = 8;
  localparam int FIFO_UNUSED = 5;
endpackage

// File: rtl/mbi_flag_bank.sv
module mbi_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_d;
  logic [W-1:0] flag_q;

  always_comb begin
    flag_d = (flag_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i))); // R3
  AST_CLEAR_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_o) & ~flag_o & ~$past(clr_i)) == '0)); // R2
endmodule

// File: rtl/mbi_irq_group.sv
module mbi_irq_group #(
  parameter int N          = 64,
  parameter int SMALL_GRP  = 4,
  parameter int SMALL_SPAN = 16,
  parameter int MID_END    = 32,
  localparam int NSMALL    = SMALL_SPAN / SMALL_GRP,
  localparam int NGRP      = NSMALL + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    en_i,
  output logic [NGRP-1:0] grp_o,
  output logic            any_o
);
  logic [NGRP-1:0] grp_d;
  logic [NGRP-1:0] grp_q;
  logic            any_d;
  logic            any_q;

  for (genvar g = 0; g < NSMALL; g++) begin : g_small
    assign grp_d[g] = |en_i[g*SMALL_GRP +: SMALL_GRP];
  end
  assign grp_d[NSMALL]   = |en_i[MID_END-1:SMALL_SPAN];
  assign grp_d[NSMALL+1] = |en_i[N-1:MID_END];
  assign any_d           = |en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
      any_q <= 1'b0;
    end else begin
      grp_q <= grp_d;
      any_q <= any_d;
    end
  end

  assign grp_o = grp_q;
  assign any_o = any_q;

  AST_ANY_MATCHES_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
    any_o == (|grp_o)); // R6
  AST_GROUP_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> (grp_o == '0)); // R4
endmodule

// File: rtl/mb_irq_aggregator.sv
module mb_irq_aggregator
  import mbi_pkg::*;
#(
  parameter int SMALL_GRP  = 4,
  parameter int SMALL_SPAN = 16,
  localparam int NGRP      = SMALL_SPAN / SMALL_GRP + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MB-1:0]   mb_done_i,
  input  logic                fifo_mode_i,
  input  logic                fifo_ovf_i,
  input  logic                fifo_warn_i,
  input  logic                fifo_avail_i,
  input  logic [NUM_STS-1:0]  sts_evt_i,
  input  logic                reg_wr_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [FLAG_W-1:0]   reg_wdata_i,
  output logic [FLAG_W-1:0]   reg_rdata_o,
  output logic [NGRP-1:0]     irq_grp_o,
  output logic                irq_any_o,
  output logic [NUM_STS-1:0]  irq_sts_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // write decode
  logic wr_flo, wr_fhi, wr_mlo, wr_mhi, wr_sf, wr_sm, wr_cnt;
  always_comb begin
    wr_flo = reg_wr_i && (reg_addr_i == RA_FLAG_LO);
    wr_fhi = reg_wr_i && (reg_addr_i == RA_FLAG_HI);
    wr_mlo = reg_wr_i && (reg_addr_i == RA_MASK_LO);
    wr_mhi = reg_wr_i && (reg_addr_i == RA_MASK_HI);
    wr_sf  = reg_wr_i && (reg_addr_i == RA_STS_FLG);
    wr_sm  = reg_wr_i && (reg_addr_i == RA_STS_MSK);
    wr_cnt = reg_wr_i && (reg_addr_i == RA_COUNT);
  end

  // read/write configuration registers
  logic [NUM_MB-1:0]  mask_d,  mask_q;
  logic [NUM_STS-1:0] smask_d, smask_q;
  logic [CNT_W-1:0]   cnt_d,   cnt_q;

  always_comb begin
    mask_d  = mask_q;
    smask_d = smask_q;
    cnt_d   = cnt_q;
    if (wr_mlo) mask_d[FLAG_W-1:0]      = reg_wdata_i;
    if (wr_mhi) mask_d[NUM_MB-1:FLAG_W] = reg_wdata_i;
    if (wr_sm)  smask_d = reg_wdata_i[NUM_STS-1:0];
    if (wr_cnt) cnt_d   = reg_wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mask_q  <= '0;
      smask_q <= '0;
      cnt_q   <= CNT_W'(NUM_MB);
    end else begin
      mask_q  <= mask_d;
      smask_q <= smask_d;
      cnt_q   <= cnt_d;
    end
  end

  // live-buffer qualification
  logic [CNT_W-1:0]  eff_cnt;
  logic [NUM_MB-1:0] live;
  logic [NUM_MB-1:0] raw_evt;
  assign eff_cnt = (cnt_q > CNT_W'(NUM_MB)) ? CNT_W'(NUM_MB) : cnt_q;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_live
    if (i < FIFO_SPAN) begin : g_fifo_capable
      assign live[i]    = fifo_mode_i ? (i >= FIFO_UNUSED) : (CNT_W'(i) < eff_cnt);
    end else begin : g_plain
      assign live[i]    = CNT_W'(i) < eff_cnt;
    end
  end

  always_comb begin
    raw_evt = mb_done_i;
    if (fifo_mode_i) begin
      raw_evt[FIFO_SPAN-1:0] = {fifo_ovf_i, fifo_warn_i, fifo_avail_i, {FIFO_UNUSED{1'b0}}};
    end
  end

  // flags
  logic [NUM_MB-1:0]  mb_flag;
  logic [NUM_MB-1:0]  mb_vis;
  logic [NUM_STS-1:0] s_flag;

  mbi_flag_bank #(.W(NUM_MB)) u_mb_flags (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .set_i  (raw_evt & live),
    .clr_i  ({(wr_fhi ? reg_wdata_i : '0), (wr_flo ? reg_wdata_i : '0)}),
    .flag_o (mb_flag)
  );

  mbi_flag_bank #(.W(NUM_STS)) u_sts_flags (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .set_i  (sts_evt_i),
    .clr_i  (wr_sf ? reg_wdata_i[NUM_STS-1:0] : '0),
    .flag_o (s_flag)
  );

  assign mb_vis = mb_flag & live;

  // interrupt lines
  mbi_irq_group #(
    .N(NUM_MB), .SMALL_GRP(SMALL_GRP), .SMALL_SPAN(SMALL_SPAN), .MID_END(FLAG_W)
  ) u_grp (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en_i  (mb_vis & mask_q),
    .grp_o (irq_grp_o),
    .any_o (irq_any_o)
  );

  logic [NUM_STS-1:0] sirq_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) sirq_q <= '0;
    else          sirq_q <= s_flag & smask_q;
  end
  assign irq_sts_o = sirq_q;

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_FLAG_LO: reg_rdata_o = mb_vis[FLAG_W-1:0];
      RA_FLAG_HI: reg_rdata_o = mb_vis[NUM_MB-1:FLAG_W];
      RA_MASK_LO: reg_rdata_o = mask_q[FLAG_W-1:0];
      RA_MASK_HI: reg_rdata_o = mask_q[NUM_MB-1:FLAG_W];
      RA_STS_FLG: reg_rdata_o = FLAG_W'(s_flag);
      RA_STS_MSK: reg_rdata_o = FLAG_W'(smask_q);
      RA_COUNT:   reg_rdata_o = FLAG_W'(cnt_q);
      default:    reg_rdata_o = '0;
    endcase
  end

  AST_FIFO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fifo_mode_i && reg_addr_i == RA_FLAG_LO) |-> (reg_rdata_o[FIFO_UNUSED-1:0] == '0)); // R7
  AST_STS_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((s_flag & smask_q) == '0) |=> (irq_sts_o == '0)); // R8
  AST_DEAD_BUFFER_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (eff_cnt == '0 && !fifo_mode_i) |=> (irq_any_o == 1'b0)); // R9
endmodule

// File: tb/mb_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module mb_irq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] mb_done;
  logic        fifo_mode, f_ovf, f_warn, f_avail;
  logic [4:0]  sts_evt;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [5:0]  irq_grp;
  logic        irq_any;
  logic [4:0]  irq_sts;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mb_irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .mb_done_i(mb_done), .fifo_mode_i(fifo_mode),
    .fifo_ovf_i(f_ovf), .fifo_warn_i(f_warn), .fifo_avail_i(f_avail),
    .sts_evt_i(sts_evt), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_grp_o(irq_grp),
    .irq_any_o(irq_any), .irq_sts_o(irq_sts)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic pulse_mb(input logic [63:0] v);
    mb_done = v; tick(); mb_done = '0;
  endtask

  function automatic int grp_of(input int i);
    if (i < 16) return i / 4;
    else if (i < 32) return 4;
    else return 5;
  endfunction

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, lo, hi;
    logic [63:0] exp64;
    rst_n = 1'b0; mb_done = '0; fifo_mode = 1'b0; f_ovf = 1'b0; f_warn = 1'b0;
    f_avail = 1'b0; sts_evt = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R10 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R10", "reset register", 64'(d), 64'd0);
    end
    rd(3'd6, d);
    check("R10", "reset count", 64'(d), 64'd64);
    check("R10", "reset irq lines", {55'd0, irq_sts, irq_any, irq_grp}, 64'd0);

    // R1 R4 R5 R6 R2: sweep every buffer singly
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    for (int i = 0; i < 64; i++) begin
      pulse_mb(64'd1 << i);
      rd(3'd0, lo); rd(3'd1, hi);
      check("R1", $sformatf("flag word buf %0d", i), {hi, lo}, 64'd1 << i);
      tick();
      check("R5", $sformatf("group line buf %0d", i), 64'(irq_grp), 64'd1 << grp_of(i));
      check("R6", $sformatf("combined buf %0d", i), 64'(irq_any), 64'd1);
      wr(i < 32 ? 3'd0 : 3'd1, 32'd1 << (i % 32));
      rd(3'd0, lo); rd(3'd1, hi);
      check("R2", $sformatf("cleared buf %0d", i), {hi, lo}, 64'd0);
      tick();
      check("R5", $sformatf("group fall buf %0d", i), {57'd0, irq_any, irq_grp}, 64'd0);
    end

    // R2: writing zero has no effect
    pulse_mb(64'd1 << 10);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h0000_0010);
    rd(3'd0, d);
    check("R2", "zero write keeps flag", 64'(d), 64'h400);

    // R3: set wins over clear in same cycle
    mb_done = 64'd1 << 10;
    wr(3'd0, 32'h400);
    mb_done = '0;
    rd(3'd0, d);
    check("R3", "set beats clear", 64'(d), 64'h400);
    wr(3'd0, 32'h400);

    // R4: masked buffers give no interrupt
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0);
    pulse_mb(64'hFFFF_FFFF_FFFF_FFFF);
    tick();
    check("R4", "masked lines", {57'd0, irq_any, irq_grp}, 64'd0);
    rd(3'd2, d);
    check("R4", "mask readback", 64'(d), 64'd0);
    wr(3'd3, 32'h8000_0000);
    tick();
    check("R4", "single mask enabled", {57'd0, irq_any, irq_grp}, 64'h60);
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0);

    // R9: live-count sweep
    for (int c = 0; c <= 100; c += 7) begin
      wr(3'd6, 32'(c));
      pulse_mb(64'hFFFF_FFFF_FFFF_FFFF);
      exp64 = (c >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << c) - 64'd1);
      rd(3'd0, lo); rd(3'd1, hi);
      check("R9", $sformatf("count %0d", c), {hi, lo}, exp64);
      wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    end
    wr(3'd6, 32'd64);

    // R7: FIFO mode
    fifo_mode = 1'b1;
    wr(3'd2, 32'hFF);
    pulse_mb(64'hFF);
    rd(3'd0, d);
    check("R7", "buffer pulses ignored", 64'(d), 64'd0);
    check("R7", "no irq from low bits", 64'(irq_any), 64'd0);
    f_ovf = 1'b1; tick(); f_ovf = 1'b0;
    rd(3'd0, d);
    check("R7", "overflow bit7", 64'(d), 64'h80);
    f_warn = 1'b1; f_avail = 1'b1; tick(); f_warn = 1'b0; f_avail = 1'b0;
    rd(3'd0, d);
    check("R7", "warn and avail", 64'(d), 64'hE0);
    tick();
    check("R7", "fifo group line", 64'(irq_grp), 64'h2);
    wr(3'd0, 32'hFF);
    fifo_mode = 1'b0;
    wr(3'd2, 32'h0);

    // R8: status sources
    for (int k = 0; k < 5; k++) begin
      wr(3'd5, 32'd1 << k);
      sts_evt = 5'd1 << k; tick(); sts_evt = '0;
      rd(3'd4, d);
      check("R8", $sformatf("status flag %0d", k), 64'(d), 64'd1 << k);
      tick();
      check("R8", $sformatf("status irq %0d", k), 64'(irq_sts), 64'd1 << k);
      wr(3'd5, 32'h0);
      tick();
      check("R8", $sformatf("status masked %0d", k), 64'(irq_sts), 64'd0);
      sts_evt = 5'd1 << k;
      wr(3'd4, 32'd1 << k);
      sts_evt = '0;
      rd(3'd4, d);
      check("R8", $sformatf("status set wins %0d", k), 64'(d), 64'd1 << k);
      wr(3'd4, 32'd1 << k);
      rd(3'd4, d);
      check("R8", $sformatf("status cleared %0d", k), 64'(d), 64'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule